// File: doc/BRIEF.md
# Dual-Channel Bus-Master Interrupt Merge

This block holds the bus-master registers of a two-channel disk controller and combines both channels' interrupt requests onto one shared, level-sensitive interrupt line. Each channel has a command register with a start/stop bit and a direction bit, a status register, a 32-bit descriptor table pointer and a device-select bit that picks one of the two device slots on that channel. Channel 0 serves devices 0 and 1 and channel 1 serves devices 2 and 3. Which of the four slots are populated is fixed by a parameter.

Software reaches the registers through a simple write port. Readback is combinational from the channel number and the offset. Devices signal the block with per-channel post and clear pulses for interrupts and with DMA-complete pulses. The block answers with one-cycle start and abort strobes. Each strobe carries the number of the target device, and the pointer it uses is always visible on an output.

Each channel runs a two-state machine, CH_IDLE and CH_RUN:
- CH_IDLE to CH_RUN when a command write raises start/stop and the selected slot is populated.
- CH_RUN to CH_IDLE when a command write lowers start/stop and the selected slot is populated, or when a DMA-complete pulse arrives.

The shared line has its own two-state machine, LN_LOW and LN_HIGH:
- LN_LOW to LN_HIGH on any post.
- LN_HIGH to LN_LOW on a clear after which no channel is left pending.

Top module: `dual_bm_irq`

## Requirements
- R1: After reset, each channel's status reads 0x20 (the device-0 DMA-capable bit, bit 5), command, pointer and select read 0, and irq_o is low.
- R2: A post pulse on a channel sets that channel's status interrupt bit (bit 2) at the next clock edge and its pending flag. It drives irq_o high from the next edge.
- R3: A clear pulse on a channel clears its status interrupt bit and its pending flag. irq_o goes low at the next edge only if the other channel has no pending interrupt; otherwise irq_o stays high.
- R4: A DMA-complete pulse clears the channel's start/stop bit (command bit 0) and its active bit (status bit 0), and sets the status interrupt bit, without changing irq_o. It takes priority over a same-cycle start/stop change on that channel.
- R5: A command write (offset 0x0) that changes start/stop from 0 to 1, with the selected slot populated, sets the active bit. It pulses dma_start for that channel for one cycle after the write edge. dma_dev carries the device number 2*channel+select.
- R6: A command write that changes start/stop from 1 to 0, with the selected slot populated, clears the active bit and pulses dma_abort for one cycle, with dma_dev set the same way.
- R7: A start/stop change while the selected slot is empty is ignored: no strobe, and start/stop and active keep their values. Instead it sets the sticky error bit (status bit 1). Writing 1 to status bit 1 clears the error bit.
- R8: The select register (offset 0x6, bit 0) picks slot 1 when set and slot 0 when clear. The device window (offset 0x7) returns the selected device's byte from dev_rdata, or zero when that slot is empty.
- R9: The descriptor table pointer sits at offset 0x4. It is written and read back as 32 bits and is driven on desc_ptr (channel c in bits 32c+31:32c).
- R10: Status bits 5 and 6 (the device 0 and device 1 DMA-capable bits) are writable. The command direction bit (bit 3) stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_ch | input | 1 | Channel addressed by the register port |
| reg_addr | input | 3 | Offset within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Readback of the addressed register |
| dev_rdata | input | 32 | Device data bytes, device n in bits 8n+7:8n |
| irq_post | input | 2 | Per-channel interrupt post pulse |
| irq_clr | input | 2 | Per-channel interrupt clear pulse |
| dma_done | input | 2 | Per-channel DMA-complete pulse |
| irq_o | output | 1 | Shared interrupt line |
| dma_start | output | 2 | Per-channel DMA start strobe |
| dma_abort | output | 2 | Per-channel DMA abort strobe |
| dma_dev | output | 4 | Device number of the last strobe, channel c in bits 2c+1:2c |
| desc_ptr | output | 64 | Descriptor table pointers, channel c in bits 32c+31:32c |

## Verification
The assertions assume that a channel never receives a post and a clear in the same cycle, and that devices only clear interrupts they posted. They also assume that DMA-complete arrives as a single-cycle pulse. The stimulus honours these assumptions: it posts and clears a channel in separate cycles, raises each pulse for exactly one cycle, and combines pulses on one cycle only across different channels or with register writes. It also exercises the cases where the assumptions are tightest: a clear while the other channel is still pending, a start toggle on an empty slot, and a DMA-complete that collides with a command write.

// File: rtl/bmirq_pkg.sv
package bmirq_pkg;
    typedef enum logic {CH_IDLE, CH_RUN} ch_state_t;
    typedef enum logic {LN_LOW, LN_HIGH} line_state_t;

    localparam int OFS_W = 3;
    localparam logic [OFS_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd2;
    localparam logic [OFS_W-1:0] OFS_PTR  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_SEL  = 3'd6;
    localparam logic [OFS_W-1:0] OFS_DEV  = 3'd7;

    localparam int CMD_RUN_BIT  = 0;
    localparam int CMD_DIR_BIT  = 3;
    localparam int ST_ACT_BIT   = 0;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_INT_BIT   = 2;
    localparam int ST_CAP0_BIT  = 5;
    localparam int ST_CAP1_BIT  = 6;
endpackage

// File: rtl/bm_channel.sv
module bm_channel
    import bmirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 32,
    parameter int CH_IDX = 0,
    parameter logic [3:0] DEV_PRESENT = 4'b0111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              post,
    input  logic              clr,
    input  logic [15:0]       dev_bytes,
    output logic [DATA_W-1:0] rdata,
    output logic              start_stb,
    output logic              abort_stb,
    output logic              stb_slot,
    output logic [PTR_W-1:0]  ptr
);
    localparam logic [1:0] SLOT_FITTED = DEV_PRESENT[2*CH_IDX +: 2];

    ch_state_t         state_q, state_d;
    logic              dir_q, err_q, int_q, cap0_q, cap1_q, sel_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              start_d, abort_d, err_set;
    logic              cmd_wr, stat_wr, toggle, sel_ok;

    assign sel_ok  = SLOT_FITTED[sel_q];
    assign cmd_wr  = wr_en && (addr == OFS_CMD);
    assign stat_wr = wr_en && (addr == OFS_STAT);
    assign toggle  = cmd_wr && (wdata[CMD_RUN_BIT] != (state_q == CH_RUN));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (!done && toggle && sel_ok) state_d = CH_RUN;
            CH_RUN:  if (done) state_d = CH_IDLE;
                     else if (toggle && sel_ok) state_d = CH_IDLE;
        endcase
    end

    // outputs of the transition
    always_comb begin
        start_d = (state_q == CH_IDLE) && (state_d == CH_RUN);
        abort_d = (state_q == CH_RUN) && (state_d == CH_IDLE) && !done;
        err_set = toggle && !sel_ok && !done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= CH_IDLE;
            start_stb <= 1'b0;
            abort_stb <= 1'b0;
            stb_slot  <= 1'b0;
        end else begin
            state_q   <= state_d;
            start_stb <= start_d;
            abort_stb <= abort_d;
            if (start_d || abort_d) stb_slot <= sel_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            err_q  <= 1'b0;
            int_q  <= 1'b0;
            cap0_q <= 1'b1;
            cap1_q <= 1'b0;
            sel_q  <= 1'b0;
            ptr_q  <= '0;
        end else begin
            int_q <= post | done | (int_q & ~clr);
            if (cmd_wr) dir_q <= wdata[CMD_DIR_BIT];
            if (err_set) err_q <= 1'b1;
            else if (stat_wr && wdata[ST_ERR_BIT]) err_q <= 1'b0;
            if (stat_wr) begin
                cap0_q <= wdata[ST_CAP0_BIT];
                cap1_q <= wdata[ST_CAP1_BIT];
            end
            if (wr_en && addr == OFS_PTR) ptr_q <= PTR_W'(wdata);
            if (wr_en && addr == OFS_SEL) sel_q <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CMD: begin
                rdata[CMD_RUN_BIT] = (state_q == CH_RUN);
                rdata[CMD_DIR_BIT] = dir_q;
            end
            OFS_STAT: begin
                rdata[ST_ACT_BIT]  = (state_q == CH_RUN);
                rdata[ST_ERR_BIT]  = err_q;
                rdata[ST_INT_BIT]  = int_q;
                rdata[ST_CAP0_BIT] = cap0_q;
                rdata[ST_CAP1_BIT] = cap1_q;
            end
            OFS_PTR: rdata = DATA_W'(ptr_q);
            OFS_SEL: rdata[0] = sel_q;
            OFS_DEV: if (sel_ok) rdata[7:0] = dev_bytes[8*sel_q +: 8];
            default: rdata = '0;
        endcase
    end

    assign ptr = ptr_q;

    assert_start_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |-> (state_q == CH_RUN));
    assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_stb |-> (state_q == CH_IDLE));
    assert_done_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == CH_IDLE && !start_stb));
    assert_empty_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !sel_ok) |=> (!start_stb && !abort_stb && $stable(state_q)));
    assert_post_sets_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> int_q);
endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import bmirq_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] post,
    input  logic [N_CH-1:0] clr,
    output logic            irq_o
);
    logic [N_CH-1:0] pend_q, pend_d;
    line_state_t     line_q, line_d;

    assign pend_d = post | (pend_q & ~clr);

    always_comb begin
        line_d = line_q;
        unique case (line_q)
            LN_LOW:  if (|post) line_d = LN_HIGH;
            LN_HIGH: if ((|clr) && !(|pend_d)) line_d = LN_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            line_q <= LN_LOW;
        end else begin
            pend_q <= pend_d;
            line_q <= line_d;
        end
    end

    assign irq_o = (line_q == LN_HIGH);

    assert_post_clr_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (post & clr) == '0);
    assert_post_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|post) |=> irq_o);
    assert_clear0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && pend_q[1] && !clr[1]) |=> irq_o);
    assert_clear1_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[1] && pend_q[0] && !clr[0]) |=> irq_o);
    assert_quiet_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0 && post == '0) |=> !irq_o);
endmodule

// File: rtl/dual_bm_irq.sv
module dual_bm_irq
    import bmirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 32,
    parameter logic [3:0] DEV_PRESENT = 4'b0111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_ch,
    input  logic [OFS_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [31:0]         dev_rdata,
    input  logic [1:0]          irq_post,
    input  logic [1:0]          irq_clr,
    input  logic [1:0]          dma_done,
    output logic                irq_o,
    output logic [1:0]          dma_start,
    output logic [1:0]          dma_abort,
    output logic [3:0]          dma_dev,
    output logic [2*PTR_W-1:0]  desc_ptr
);
    localparam int N_CH = 2;

    logic [DATA_W-1:0] ch_rdata [N_CH];
    logic [N_CH-1:0]   ch_slot;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        bm_channel #(
            .DATA_W(DATA_W), .PTR_W(PTR_W), .CH_IDX(c), .DEV_PRESENT(DEV_PRESENT)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_wr && (reg_ch == 1'(c))),
            .addr      (reg_addr),
            .wdata     (reg_wdata),
            .done      (dma_done[c]),
            .post      (irq_post[c]),
            .clr       (irq_clr[c]),
            .dev_bytes (dev_rdata[16*c +: 16]),
            .rdata     (ch_rdata[c]),
            .start_stb (dma_start[c]),
            .abort_stb (dma_abort[c]),
            .stb_slot  (ch_slot[c]),
            .ptr       (desc_ptr[PTR_W*c +: PTR_W])
        );
        assign dma_dev[2*c +: 2] = {1'(c), ch_slot[c]};
    end

    assign reg_rdata = ch_rdata[reg_ch];

    irq_merge #(.N_CH(N_CH)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .post  (irq_post),
        .clr   (irq_clr),
        .irq_o (irq_o)
    );
endmodule

// File: tb/sim_dual_bm_irq.sv
module sim_dual_bm_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_ch = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] dev_rdata = 32'hD3C2B1A0;
    logic [1:0]  irq_post = 2'b00, irq_clr = 2'b00, dma_done = 2'b00;
    logic        irq_o;
    logic [1:0]  dma_start, dma_abort;
    logic [3:0]  dma_dev;
    logic [63:0] desc_ptr;

    localparam logic [3:0] FITTED = 4'b0111;

    dual_bm_irq u0 (.*);

    always #4 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit running = 1'b0, finished = 1'b0;

    // reference model state
    bit m_run[2], m_dir[2], m_err[2], m_int[2], m_pend[2], m_cap0[2], m_cap1[2], m_sel[2];
    bit m_start[2], m_abort[2];
    logic [31:0] m_ptr[2];
    logic [1:0]  m_dev[2];
    bit m_irq;

    function automatic bit fitted(int c, bit s);
        return FITTED[2*c + int'(s)];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_run[c] = 0; m_dir[c] = 0; m_err[c] = 0; m_int[c] = 0; m_pend[c] = 0;
                m_cap0[c] = 1; m_cap1[c] = 0; m_sel[c] = 0; m_start[c] = 0; m_abort[c] = 0;
                m_ptr[c] = 0; m_dev[c] = 2'(2*c);
            end
            m_irq = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                m_start[c] = 0; m_abort[c] = 0;
                if (irq_post[c]) begin m_pend[c] = 1; m_int[c] = 1; end
                else if (irq_clr[c]) begin m_pend[c] = 0; m_int[c] = 0; end
                if (dma_done[c]) begin m_int[c] = 1; m_run[c] = 0; end
                if (reg_wr && int'(reg_ch) == c) begin
                    case (reg_addr)
                        3'd0: begin
                            m_dir[c] = reg_wdata[3];
                            if (!dma_done[c] && reg_wdata[0] != m_run[c]) begin
                                if (fitted(c, m_sel[c])) begin
                                    if (m_run[c]) m_abort[c] = 1; else m_start[c] = 1;
                                    m_dev[c] = 2'(2*c + int'(m_sel[c]));
                                    m_run[c] = reg_wdata[0];
                                end else m_err[c] = 1;
                            end
                        end
                        3'd2: begin
                            m_cap0[c] = reg_wdata[5]; m_cap1[c] = reg_wdata[6];
                            if (reg_wdata[1]) m_err[c] = 0;
                        end
                        3'd4: m_ptr[c] = reg_wdata;
                        3'd6: m_sel[c] = reg_wdata[0];
                        default: ;
                    endcase
                end
            end
            m_irq = m_pend[0] | m_pend[1];
        end
    end

    function automatic logic [31:0] exp_rdata();
        int c = int'(reg_ch);
        logic [31:0] v = 32'd0;
        case (reg_addr)
            3'd0: begin v[0] = m_run[c]; v[3] = m_dir[c]; end
            3'd2: begin v[0] = m_run[c]; v[1] = m_err[c]; v[2] = m_int[c];
                        v[5] = m_cap0[c]; v[6] = m_cap1[c]; end
            3'd4: v = m_ptr[c];
            3'd6: v[0] = m_sel[c];
            3'd7: if (fitted(c, m_sel[c])) v[7:0] = dev_rdata[8*(2*c + int'(m_sel[c])) +: 8];
            default: v = 32'd0;
        endcase
        return v;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R2/R3 irq_o", 64'(irq_o), 64'(m_irq));
            for (int c = 0; c < 2; c++) begin
                chk("R5 dma_start", 64'(dma_start[c]), 64'(m_start[c]));
                chk("R6 dma_abort", 64'(dma_abort[c]), 64'(m_abort[c]));
                if (m_start[c] || m_abort[c])
                    chk("R5/R6 dma_dev", 64'(dma_dev[2*c +: 2]), 64'(m_dev[c]));
                chk("R9 desc_ptr", 64'(desc_ptr[32*c +: 32]), 64'(m_ptr[c]));
            end
            chk("R4/R7/R8/R10 reg_rdata", 64'(reg_rdata), 64'(exp_rdata()));
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk); #2;
            reg_wr = 0; irq_post = 0; irq_clr = 0; dma_done = 0;
        end
    endtask

    task automatic wr(bit ch, logic [2:0] a, logic [31:0] d);
        reg_wr = 1; reg_ch = ch; reg_addr = a; reg_wdata = d;
        cyc();
    endtask

    task automatic look(bit ch, logic [2:0] a);
        reg_ch = ch; reg_addr = a; #1;
    endtask

    initial begin
        reg_addr = 3'd2;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        running = 1'b1;
        #2;
        // R1 reset state
        chk("R1 irq low", 64'(irq_o), 64'd0);
        look(0, 3'd2); chk("R1 status ch0", 64'(reg_rdata), 64'h20);
        look(1, 3'd2); chk("R1 status ch1", 64'(reg_rdata), 64'h20);
        look(1, 3'd4); chk("R1 pointer ch1", 64'(reg_rdata), 64'h0);
        cyc();
        // R9 pointer
        wr(0, 3'd4, 32'h1000_0040);
        look(0, 3'd4); chk("R9 pointer readback", 64'(reg_rdata), 64'h1000_0040);
        wr(1, 3'd4, 32'hCAFE_0100);
        // R5 start on channel 0 slot 0 with direction
        wr(0, 3'd0, 32'h9);
        #1 chk("R5 start strobe ch0", 64'(dma_start[0]), 64'd1);
        chk("R5 device 0", 64'(dma_dev[1:0]), 64'd0);
        look(0, 3'd0); cyc();
        // R4 completion
        dma_done[0] = 1; look(0, 3'd2); cyc();
        #1 chk("R4 status after done", 64'(reg_rdata), 64'h24);
        chk("R4 irq unchanged", 64'(irq_o), 64'd0);
        // R2 and R3 merging
        irq_clr[0] = 1; cyc();
        irq_post[0] = 1; cyc();
        #1 chk("R2 irq after post", 64'(irq_o), 64'd1);
        irq_post[1] = 1; cyc();
        irq_clr[0] = 1; cyc();
        #1 chk("R3 line held by ch1", 64'(irq_o), 64'd1);
        irq_clr[1] = 1; cyc();
        #1 chk("R3 line released", 64'(irq_o), 64'd0);
        irq_post = 2'b11; cyc(2);
        irq_clr = 2'b11; cyc();
        irq_post[1] = 1; irq_clr[0] = 1; cyc();
        irq_post[0] = 1; irq_clr[1] = 1; cyc();
        irq_clr[0] = 1; cyc(2);
        // R7 empty slot on channel 1 (device 3 absent)
        wr(1, 3'd6, 32'h1);
        look(1, 3'd7); chk("R8 empty slot reads zero", 64'(reg_rdata), 64'h0);
        wr(1, 3'd0, 32'h1);
        #1 chk("R7 no start on empty slot", 64'(dma_start[1]), 64'd0);
        look(1, 3'd2); chk("R7 error set", 64'(reg_rdata), 64'h22);
        wr(1, 3'd0, 32'h1);
        wr(1, 3'd2, 32'h22);
        look(1, 3'd2); chk("R7 error cleared", 64'(reg_rdata), 64'h20);
        // R5 R6 on channel 1 slot 0 (device 2)
        wr(1, 3'd6, 32'h0);
        look(1, 3'd7); chk("R8 device 2 byte", 64'(reg_rdata), 64'hC2);
        wr(1, 3'd0, 32'h1);
        #1 chk("R5 device 2 number", 64'(dma_dev[3:2]), 64'd2);
        cyc();
        wr(1, 3'd0, 32'h1);
        wr(1, 3'd6, 32'h1);
        wr(1, 3'd0, 32'h0);
        #1 chk("R7 abort ignored on empty slot", 64'(dma_abort[1]), 64'd0);
        wr(1, 3'd6, 32'h0);
        wr(1, 3'd0, 32'h0);
        #1 chk("R6 abort strobe", 64'(dma_abort[1]), 64'd1);
        cyc();
        // R8 channel 0 slot 1 (device 1)
        wr(0, 3'd6, 32'h1);
        look(0, 3'd7); chk("R8 device 1 byte", 64'(reg_rdata), 64'hB1);
        wr(0, 3'd0, 32'h1);
        #1 chk("R5 device 1 number", 64'(dma_dev[1:0]), 64'd1);
        // R4 done collides with stop write
        dma_done[0] = 1; reg_wr = 1; reg_ch = 0; reg_addr = 3'd0; reg_wdata = 32'h0; cyc();
        #1 chk("R4 done wins over stop", 64'(dma_abort[0]), 64'd0);
        // R4 done collides with start write
        dma_done[0] = 1; reg_wr = 1; reg_ch = 0; reg_addr = 3'd0; reg_wdata = 32'h1; cyc();
        #1 chk("R4 done wins over start", 64'(dma_start[0]), 64'd0);
        // R10 capability bits and direction
        wr(0, 3'd2, 32'h40);
        look(0, 3'd2); chk("R10 capability bits", 64'(reg_rdata) & 64'h60, 64'h40);
        wr(0, 3'd0, 32'h8);
        look(0, 3'd0); chk("R10 direction bit", 64'(reg_rdata), 64'h8);
        for (int a = 0; a < 8; a++) begin
            look(0, 3'(a)); cyc();
            look(1, 3'(a)); cyc();
        end
        cyc(2);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule